// File: doc/BRIEF.md
# Time-aware transmit gate scheduler

This block drives one gate-open line per transmit queue from a cyclic gate control list that follows a PTP time base. Software loads list entries through a small write port into a shadow (pending) bank while the other bank is being executed. Each entry carries a gate bitmap and an interval. The scheduler steps through the active entries. It restarts the list at each cycle boundary. On request, it exchanges the two banks at a cycle start.

The time base arrives as a seconds/nanoseconds pair with the nanoseconds always below 1,000,000,000. The base time, the cycle time and all internal deadlines use the same form. A small lead offset is added to the incoming time so that the gates move early by a fixed pipeline latency. A guard offset lengthens every entry by the same amount. None of the interfaces carries a data stream, so every pin is a plain control or status level with no valid/ready handshake.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, every bit of `gate_open` is 1 and `swap_done` is 0. Bank 0 is the active bank and its length is 0.
- R2: While `enable` is low, all gates are open no later than two clocks after it falls. Raising `enable` again restarts alignment from the base time.
- R3: While the effective time is earlier than the first cycle start, all gates stay open. The effective time is the PTP time plus `lead_ns`.
- R4: The first cycle starts at the earliest time base + k*cycle (k >= 0) that is not earlier than the effective time seen when scheduling is enabled.
- R5: An entry holds the gate bitmap in bits [31:24] and the interval in nanoseconds in bits [23:0]. Bit q of the bitmap opens queue q when it is 1. Entries run in index order starting at 0.
- R6: Each entry stays in force for its interval plus `guard_ns` nanoseconds.
- R7: An entry still running when the cycle time elapses is cut short, and index 0 starts at that cycle boundary.
- R8: When the last active entry expires before the cycle time elapses, a new cycle with index 0 starts at once, at that expiry time.
- R9: Writes always go to the pending bank. The gates produced from the active list are never changed by them.
- R10: `swap_req` is acted on only at a cycle start. The banks exchange, `list_len` is sampled as the new length (clamped to the depth), and `swap_done` pulses high for one clock.
- R11: An active length of 0 keeps all gates open for the whole cycle.
- R12: All deadline comparisons use the effective time, so a lead of L ns moves every gate edge L ns earlier in PTP time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global scheduling enable |
| swap_req | input | 1 | Request to exchange to the pending list at the next cycle start |
| swap_done | output | 1 | One-clock pulse when the exchange has happened |
| ptp_sec | input | 32 | Current PTP seconds |
| ptp_ns | input | 30 | Current PTP nanoseconds (< 1e9) |
| lead_ns | input | 8 | Latency lead added to PTP time |
| guard_ns | input | 8 | Guard added to every entry interval |
| base_sec | input | 32 | Base time seconds (high word) |
| base_ns | input | 30 | Base time nanoseconds (low word) |
| cyc_sec | input | 32 | Cycle time seconds |
| cyc_ns | input | 30 | Cycle time nanoseconds (< 1e9) |
| list_len | input | 5 | Entry count for the pending list, sampled at exchange |
| wr_en | input | 1 | Write strobe for the pending bank |
| wr_idx | input | 4 | Pending-bank entry index |
| wr_data | input | 32 | Entry value (bitmap and interval) |
| gate_open | output | 8 | Per-queue gate-open lines |

## Verification
A modelled PTP counter advances 5 ns per clock and crosses a second boundary before the base time. The first list has a last entry that overruns a 700 ns cycle. Its sample points are placed so that a lost guard offset or a missing truncation gives a different bitmap. A second list, exchanged in the middle of the run, ends well inside the cycle, which separates the early-wrap path from the cycle-end path. The bench then re-enables with the base time already past and a non-zero lead, so a start on the wrong boundary or an ignored lead shows up at a point where only the correct schedule is open. A final exchange to a zero-length list checks the all-open case, and the times of the three exchange pulses are compared with the boundaries where they should occur.

// File: rtl/tas_pkg.sv
package tas_pkg;

  localparam logic [30:0] NS_PER_SEC = 31'd1_000_000_000;

  typedef struct packed {
    logic [31:0] sec;
    logic [29:0] ns;
  } ptp_time_t;

  // add a nanosecond span below one second, carrying into seconds
  function automatic ptp_time_t t_add_ns(input ptp_time_t a, input logic [30:0] d);
    ptp_time_t r;
    logic [30:0] s;
    s = {1'b0, a.ns} + d;
    if (s >= NS_PER_SEC) begin
      r.ns  = 30'(s - NS_PER_SEC);
      r.sec = a.sec + 32'd1;
    end else begin
      r.ns  = s[29:0];
      r.sec = a.sec;
    end
    return r;
  endfunction

  function automatic ptp_time_t t_add(input ptp_time_t a, input ptp_time_t b);
    ptp_time_t r;
    r = t_add_ns(a, {1'b0, b.ns});
    r.sec = r.sec + b.sec;
    return r;
  endfunction

  function automatic logic t_ge(input ptp_time_t a, input ptp_time_t b);
    return (a.sec > b.sec) || ((a.sec == b.sec) && (a.ns >= b.ns));
  endfunction

endpackage

// File: rtl/tas_gcl_store.sv
module tas_gcl_store #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 32,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_bank,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               rd_a_bank,
  input  logic [IDX_W-1:0]   rd_a_idx,
  output logic [ENTRY_W-1:0] rd_a_data,
  input  logic               rd_b_bank,
  input  logic [IDX_W-1:0]   rd_b_idx,
  output logic [ENTRY_W-1:0] rd_b_data
);

  logic [ENTRY_W-1:0] bank_a_q [2];
  logic [ENTRY_W-1:0] bank_b_q [2];

  for (genvar gb = 0; gb < 2; gb++) begin : g_bank
    logic [ENTRY_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en && (wr_bank == 1'(gb))) begin
        mem_q[wr_idx] <= wr_data;
      end
    end

    assign bank_a_q[gb] = mem_q[rd_a_idx];
    assign bank_b_q[gb] = mem_q[rd_b_idx];
  end

  assign rd_a_data = bank_a_q[rd_a_bank];
  assign rd_b_data = bank_b_q[rd_b_bank];

  // writes never land in the bank the gates are read from
  assert_wr_pending_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_bank != rd_a_bank));

endmodule

// File: rtl/tas_cycle_ctrl.sv
module tas_cycle_ctrl
  import tas_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NUM_Q   = 8,
  parameter int IVL_W   = 24,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1),
  localparam int ENTRY_W = NUM_Q + IVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               swap_req,
  input  ptp_time_t          now_t,
  input  logic [7:0]         lead_ns,
  input  logic [7:0]         guard_ns,
  input  ptp_time_t          base_t,
  input  ptp_time_t          cyc_t,
  input  logic [LEN_W-1:0]   list_len,
  input  logic [ENTRY_W-1:0] look_data,
  output logic               look_bank,
  output logic [IDX_W-1:0]   look_idx,
  output logic               act_bank,
  output logic [IDX_W-1:0]   act_idx,
  output logic               run_gates,
  output logic               swap_done
);

  typedef enum logic [1:0] {S_IDLE, S_ALIGN, S_WAIT, S_RUN} st_e;

  st_e              st_q;
  ptp_time_t        cs_q, cyc_end_q, ent_end_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic             bank_q, done_q;

  ptp_time_t        eff_t, st_t;
  logic [LEN_W-1:0] new_len;
  logic [30:0]      dur;
  logic             at_last, ent_due, cyc_due, last_over;
  logic             start, advance, swap_now;

  always_comb begin
    eff_t     = t_add_ns(now_t, 31'(lead_ns));
    ent_due   = t_ge(eff_t, ent_end_q);
    cyc_due   = t_ge(eff_t, cyc_end_q);
    at_last   = (len_q != '0) && ((LEN_W'(idx_q) + LEN_W'(1)) == len_q);
    last_over = at_last && ent_due;
    start     = 1'b0;
    st_t      = cyc_end_q;
    if (st_q == S_WAIT) begin
      start = t_ge(eff_t, cs_q);
      st_t  = cs_q;
    end else if (st_q == S_RUN) begin
      start = cyc_due || last_over;
      st_t  = (last_over && !t_ge(ent_end_q, cyc_end_q)) ? ent_end_q : cyc_end_q;
    end
    advance   = (st_q == S_RUN) && !start && (len_q != '0) && !at_last && ent_due;
    swap_now  = start && swap_req;
    look_bank = swap_now ? ~bank_q : bank_q;
    look_idx  = start ? '0 : idx_q + IDX_W'(1);
    new_len   = (list_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : list_len;
    dur       = 31'(look_data[IVL_W-1:0]) + 31'(guard_ns);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cs_q      <= '0;
      cyc_end_q <= '0;
      ent_end_q <= '0;
      idx_q     <= '0;
      len_q     <= '0;
      bank_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!enable) begin
        st_q <= S_IDLE;
      end else begin
        case (st_q)
          S_IDLE: begin
            cs_q <= base_t;
            st_q <= S_ALIGN;
          end
          S_ALIGN: begin
            if (t_ge(cs_q, eff_t)) st_q <= S_WAIT;
            else                   cs_q <= t_add(cs_q, cyc_t);
          end
          default: begin
            if (start) begin
              cs_q      <= st_t;
              cyc_end_q <= t_add(st_t, cyc_t);
              ent_end_q <= t_add_ns(st_t, dur);
              idx_q     <= '0;
              len_q     <= swap_now ? new_len : len_q;
              bank_q    <= look_bank;
              done_q    <= swap_now;
              st_q      <= S_RUN;
            end else if (advance) begin
              idx_q     <= idx_q + IDX_W'(1);
              ent_end_q <= t_add_ns(ent_end_q, dur);
            end
          end
        endcase
      end
    end
  end

  assign act_bank  = bank_q;
  assign act_idx   = idx_q;
  assign run_gates = (st_q == S_RUN) && (len_q != '0);
  assign swap_done = done_q;

  assert_idx_in_list_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && len_q != '0) |-> (LEN_W'(idx_q) < len_q));

  assert_idx_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && $past(st_q) == S_RUN && idx_q != $past(idx_q))
      |-> (idx_q == '0 || idx_q == $past(idx_q) + IDX_W'(1)));

  assert_swap_at_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == S_RUN && idx_q == '0 && bank_q != $past(bank_q)));

  assert_ns_normalised_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN) |-> ({1'b0, cyc_end_q.ns} < NS_PER_SEC && {1'b0, ent_end_q.ns} < NS_PER_SEC));

endmodule

// File: rtl/tas_gate_out.sv
module tas_gate_out #(
  parameter int NUM_Q   = 8,
  parameter int ENTRY_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_gates,
  input  logic [ENTRY_W-1:0] entry,
  output logic [NUM_Q-1:0]   gate_open
);

  logic [NUM_Q-1:0] gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gate_q <= '1;
    else if (run_gates) gate_q <= entry[ENTRY_W-1 -: NUM_Q];
    else                gate_q <= '1;
  end

  assign gate_open = gate_q;

endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
  import tas_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NUM_Q   = 8,
  parameter int IVL_W   = 24,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1),
  localparam int ENTRY_W = NUM_Q + IVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               swap_req,
  output logic               swap_done,
  input  logic [31:0]        ptp_sec,
  input  logic [29:0]        ptp_ns,
  input  logic [7:0]         lead_ns,
  input  logic [7:0]         guard_ns,
  input  logic [31:0]        base_sec,
  input  logic [29:0]        base_ns,
  input  logic [31:0]        cyc_sec,
  input  logic [29:0]        cyc_ns,
  input  logic [LEN_W-1:0]   list_len,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [NUM_Q-1:0]   gate_open
);

  ptp_time_t          now_t, base_t, cyc_t;
  logic               look_bank, act_bank, run_gates;
  logic [IDX_W-1:0]   look_idx, act_idx;
  logic [ENTRY_W-1:0] look_data, act_data;

  assign now_t  = '{sec: ptp_sec,  ns: ptp_ns};
  assign base_t = '{sec: base_sec, ns: base_ns};
  assign cyc_t  = '{sec: cyc_sec,  ns: cyc_ns};

  tas_gcl_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_bank   (~act_bank),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_a_bank (act_bank),
    .rd_a_idx  (act_idx),
    .rd_a_data (act_data),
    .rd_b_bank (look_bank),
    .rd_b_idx  (look_idx),
    .rd_b_data (look_data)
  );

  tas_cycle_ctrl #(.DEPTH(DEPTH), .NUM_Q(NUM_Q), .IVL_W(IVL_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .swap_req  (swap_req),
    .now_t     (now_t),
    .lead_ns   (lead_ns),
    .guard_ns  (guard_ns),
    .base_t    (base_t),
    .cyc_t     (cyc_t),
    .list_len  (list_len),
    .look_data (look_data),
    .look_bank (look_bank),
    .look_idx  (look_idx),
    .act_bank  (act_bank),
    .act_idx   (act_idx),
    .run_gates (run_gates),
    .swap_done (swap_done)
  );

  tas_gate_out #(.NUM_Q(NUM_Q), .ENTRY_W(ENTRY_W)) gate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_gates (run_gates),
    .entry     (act_data),
    .gate_open (gate_open)
  );

  assert_disabled_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && $past(!enable)) |=> (&gate_open));

endmodule

// File: tb/tas_gate_sched_tb_top.sv
`timescale 1ns/1ps
module tas_gate_sched_tb_top;

  localparam longint BASE_ABS = 64'sd2_000_000_000;
  localparam longint NS_SEC   = 64'sd1_000_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, swap_req = 1'b0, swap_done;
  logic [31:0] ptp_sec;
  logic [29:0] ptp_ns;
  logic [7:0]  lead_ns = 8'd0, guard_ns = 8'd50;
  logic [4:0]  list_len = 5'd3;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  gate_open;
  longint      rel = -1000;
  int          n_tests = 0, n_fail = 0, swap_n = 0;
  longint      swap_t [4];

  always #2.5 clk = ~clk;

  assign ptp_sec = 32'((BASE_ABS + rel) / NS_SEC);
  assign ptp_ns  = 30'((BASE_ABS + rel) % NS_SEC);

  tas_gate_sched dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .swap_req(swap_req),
    .swap_done(swap_done), .ptp_sec(ptp_sec), .ptp_ns(ptp_ns),
    .lead_ns(lead_ns), .guard_ns(guard_ns), .base_sec(32'd2), .base_ns(30'd0),
    .cyc_sec(32'd0), .cyc_ns(30'd700), .list_len(list_len), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .gate_open(gate_open)
  );

  // modelled PTP counter: 5 ns per 200 MHz clock
  initial forever @(posedge clk) rel <= rel + 5;

  // exchange monitor: records pulse times and drops the request
  initial forever @(negedge clk) begin
    if (swap_done) begin
      if (swap_n < 4) swap_t[swap_n] = rel;
      swap_n++;
      swap_req = 1'b0;
    end
  end

  localparam int VT_N = 9;
  localparam int VT_T [VT_N] = '{-500, 175, 330, 475, 580, 650, 875, 1175, 1350};
  localparam logic [7:0] VT_G [VT_N] = '{8'hFF, 8'h01, 8'h01, 8'h06, 8'h06, 8'h80, 8'h01, 8'h06, 8'h80};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at t=%0d", tag, act, exp, rel);
    end
  endtask

  task automatic gate_at(input string tag, input longint t, input logic [7:0] exp);
    while (rel < t) @(negedge clk);
    chk(tag, 32'(gate_open), 32'(exp));
  endtask

  task automatic wait_until(input longint t);
    while (rel < t) @(negedge clk);
  endtask

  task automatic wr_ent(input logic [3:0] i, input logic [7:0] bm, input logic [23:0] ivl);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = {bm, ivl};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_swap(input string tag, input int k, input longint t);
    n_tests++;
    if (swap_n <= k || swap_t[k] < t || swap_t[k] > t + 25) begin
      n_fail++;
      $display("FAIL %s: exchange %0d at t=%0d expected in [%0d,%0d]", tag, k,
               (swap_n > k) ? swap_t[k] : -1, t, t + 25);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 gates after reset", 32'(gate_open), 32'hFF);
    chk("R1 swap_done after reset", 32'(swap_done), 32'h0);
    rst_n = 1'b1;
    // list A into the pending bank (R5 layout: bitmap [31:24], interval [23:0])
    wr_ent(4'd0, 8'h01, 24'd300);
    wr_ent(4'd1, 8'h06, 24'd200);
    wr_ent(4'd2, 8'h80, 24'd150);
    @(negedge clk);
    swap_req = 1'b1;
    enable   = 1'b1;
    // R3 R5 R6 R7: table walk, list A with 50 ns guard, 700 ns cycle
    for (int i = 0; i < VT_N; i++) gate_at("R3 R5 R6 R7 table", VT_T[i], VT_G[i]);
    chk_swap("R10 first exchange at base", 0, 0);
    // list B written while A runs
    wait_until(1450);
    wr_ent(4'd0, 8'h0F, 24'd100);
    wr_ent(4'd1, 8'hF0, 24'd150);
    @(negedge clk);
    list_len = 5'd2;
    swap_req = 1'b1;
    gate_at("R9 active list untouched by writes", 1600, 8'h01);
    gate_at("R9 active list before boundary", 2050, 8'h80);
    gate_at("R10 new list after boundary", 2175, 8'h0F);
    gate_at("R6 second entry of new list", 2350, 8'hF0);
    gate_at("R8 early wrap after last entry", 2525, 8'h0F);
    gate_at("R8 second pass", 2700, 8'hF0);
    chk_swap("R10 exchange at cycle boundary", 1, 2100);
    // R2: disable
    wait_until(2900);
    enable = 1'b0;
    gate_at("R2 disabled opens all", 2950, 8'hFF);
    // R4 R12: re-enable with base in the past and 100 ns lead
    wait_until(3100);
    lead_ns = 8'd100;
    enable  = 1'b1;
    gate_at("R4 open until aligned start", 3300, 8'hFF);
    gate_at("R12 lead moves start earlier", 3450, 8'h0F);
    gate_at("R12 lead second entry", 3650, 8'hF0);
    gate_at("R8 wrap with lead", 3825, 8'h0F);
    // R11: exchange to a zero-length list
    wait_until(3850);
    list_len = 5'd0;
    swap_req = 1'b1;
    gate_at("R11 zero length keeps gates open", 4300, 8'hFF);
    chk_swap("R10 exchange with lead", 2, 4100);
    chk("R10 exchange count", 32'(swap_n), 32'd3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule